// File: doc/BRIEF.md
# Outbound Address Translator

This block maps 32-bit local addresses onto a 64-bit link-side address space for the outbound direction of a PCIe root-port bridge. It holds three translation regions. Each region has a base, an inclusive limit, a 64-bit target, a transaction-type code and an enable bit. Software programs the regions through a small register window on a plain 32-bit register bus. A viewport index register picks which region the other window registers reach, so one set of register offsets serves every region.

A lookup is one local address with a valid strobe. One cycle later the block returns the outcome. On a hit it gives the translated address, the type code and the region that hit. On a miss the hit flag is low. Building packets from the result happens downstream of this block.

Top module: `ob_addr_xlate`

## Requirements
- R1: After reset the viewport index and every region register read as zero, every region is disabled, and every lookup misses.
- R2: The window starts at register address 0x900 and uses these offsets: +0x0 viewport index (32 bits); +0x4 type code, kept in bits 4:0 with the rest reading zero; +0x8 enable, kept in bit 31 with the rest reading zero; +0xC base low; +0x10 base high; +0x14 limit; +0x18 target low; +0x1C target high. The last five keep all 32 bits.
- R3: A write to any offset from +0x4 to +0x1C changes only the region selected by the viewport index, and a read returns that region's value.
- R4: While the viewport index is 3 or more, writes to offsets +0x4 to +0x1C change no region and reads of those offsets return zero.
- R5: A region hits only when it is enabled and base low ≤ address ≤ limit, with both ends included. A region whose limit is below its base never hits.
- R6: On a hit the output address is the 64-bit value {target high, target low} plus (address − base low), with the carry going into the high half.
- R7: On a hit the type output carries the region's 5-bit type code (0 memory, 1 locked memory read, 2 I/O, 4 type-0 config, 5 type-1 config) and the region output carries the region number.
- R8: When several enabled regions match, the lowest-numbered one wins.
- R9: outValid is high exactly one cycle after lkValid. On a miss, outHit, outAddr, outType and outRegion are all zero.
- R10: Register addresses outside 0x900 to 0x91C, and unaligned addresses, read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| lkValid | input | 1 | Lookup request valid |
| lkAddr | input | 32 | Local address to translate |
| outValid | output | 1 | Lookup result valid |
| outHit | output | 1 | A region matched |
| outRegion | output | 2 | Winning region number |
| outAddr | output | 64 | Translated address |
| outType | output | 5 | Transaction-type code of the winning region |

## Verification
A region register that holds a wrong value shows up on the very next lookup of an address near that region's edges. It appears as a hit flag that flips at the wrong address, a shifted translated address, or a wrong type code, one cycle after the request. Because of this, the sweeps focus on addresses at base−1, base, limit and limit+1, and on targets where the low half carries into the high half. A viewport that decodes the wrong region shows up at once in register read-back and in lookups of the regions that were not meant to change.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  typedef enum logic [2:0] {
    F_VIEW  = 3'd0,
    F_TYPE  = 3'd1,
    F_ENA   = 3'd2,
    F_BLO   = 3'd3,
    F_BHI   = 3'd4,
    F_LIM   = 3'd5,
    F_TLO   = 3'd6,
    F_THI   = 3'd7
  } fieldSel_e;

  typedef struct packed {
    logic      fieldWr;
    fieldSel_e sel;
    logic      lkCapture;
  } strobes_t;
endpackage

// File: rtl/ob_xlate_ctrl.sv
module ob_xlate_ctrl
  import ob_xlate_pkg::*;
#(
  parameter int AW          = 32,
  parameter int REG_AW      = 12,
  parameter int WIN_BASE    = 'h900,
  parameter int NUM_REGIONS = 3,
  parameter int IDX_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regWrData,
  input  logic              lkValid,
  input  logic [AW-1:0]     dpRdData,
  output strobes_t          stb,
  output logic [IDX_W-1:0]  regionSel,
  output logic [AW-1:0]     regRdData
);
  localparam logic [REG_AW-1:0] WIN_B = REG_AW'(WIN_BASE);

  logic [AW-1:0]     viewport;
  logic [REG_AW-1:0] off;
  logic              inWindow;
  logic              vpValid;
  fieldSel_e         field;

  assign off      = regAddr - WIN_B;
  assign inWindow = (regAddr >= WIN_B) && (off[REG_AW-1:5] == '0) && (off[1:0] == 2'b00);
  assign field    = fieldSel_e'(off[4:2]);
  assign vpValid  = viewport < AW'(NUM_REGIONS);

  always_ff @(posedge clk) begin
    if (!rstN) viewport <= '0;
    else if (regWrEn && inWindow && field == F_VIEW) viewport <= regWrData;
  end

  assign regionSel     = viewport[IDX_W-1:0];
  assign stb.fieldWr   = regWrEn && inWindow && (field != F_VIEW) && vpValid;
  assign stb.sel       = field;
  assign stb.lkCapture = lkValid;

  always_comb begin
    regRdData = '0;
    if (inWindow) begin
      if (field == F_VIEW) regRdData = viewport;
      else if (vpValid)    regRdData = dpRdData;
    end
  end
endmodule

// File: rtl/ob_xlate_dp.sv
module ob_xlate_dp
  import ob_xlate_pkg::*;
#(
  parameter int AW          = 32,
  parameter int TYPE_W      = 5,
  parameter int NUM_REGIONS = 3,
  parameter int IDX_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [IDX_W-1:0]  regionSel,
  input  logic [AW-1:0]     regWrData,
  input  logic [AW-1:0]     lkAddr,
  output logic [AW-1:0]     dpRdData,
  output logic              outValid,
  output logic              outHit,
  output logic [IDX_W-1:0]  outRegion,
  output logic [2*AW-1:0]   outAddr,
  output logic [TYPE_W-1:0] outType
);
  logic              hitVec [NUM_REGIONS];
  logic [2*AW-1:0]   xlat   [NUM_REGIONS];
  logic [TYPE_W-1:0] typVec [NUM_REGIONS];
  logic [AW-1:0]     rdVec  [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic [TYPE_W-1:0] typ;
    logic              ena;
    logic [AW-1:0]     baseLo, baseHi, limit, tgtLo, tgtHi;
    logic              wrMe;

    assign wrMe = stb.fieldWr && (regionSel == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        typ <= '0; ena <= 1'b0;
        baseLo <= '0; baseHi <= '0; limit <= '0; tgtLo <= '0; tgtHi <= '0;
      end else if (wrMe) begin
        case (stb.sel)
          F_TYPE: typ    <= regWrData[TYPE_W-1:0];
          F_ENA:  ena    <= regWrData[AW-1];
          F_BLO:  baseLo <= regWrData;
          F_BHI:  baseHi <= regWrData;
          F_LIM:  limit  <= regWrData;
          F_TLO:  tgtLo  <= regWrData;
          F_THI:  tgtHi  <= regWrData;
          default: ;
        endcase
      end
    end

    always_comb begin
      case (stb.sel)
        F_TYPE:  rdVec[g] = AW'(typ);
        F_ENA:   rdVec[g] = {ena, {(AW-1){1'b0}}};
        F_BLO:   rdVec[g] = baseLo;
        F_BHI:   rdVec[g] = baseHi;
        F_LIM:   rdVec[g] = limit;
        F_TLO:   rdVec[g] = tgtLo;
        F_THI:   rdVec[g] = tgtHi;
        default: rdVec[g] = '0;
      endcase
    end

    assign hitVec[g] = ena && (lkAddr >= baseLo) && (lkAddr <= limit);
    assign xlat[g]   = {tgtHi, tgtLo} + {{AW{1'b0}}, lkAddr - baseLo};
    assign typVec[g] = typ;
  end

  always_comb begin
    dpRdData = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (regionSel == IDX_W'(i)) dpRdData = rdVec[i];
  end

  logic              selHit;
  logic [IDX_W-1:0]  selIdx;
  logic [2*AW-1:0]   selAddr;
  logic [TYPE_W-1:0] selType;

  always_comb begin
    selHit = 1'b0; selIdx = '0; selAddr = '0; selType = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selHit  = 1'b1;
        selIdx  = IDX_W'(i);
        selAddr = xlat[i];
        selType = typVec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outHit <= 1'b0; outRegion <= '0; outAddr <= '0; outType <= '0;
    end else begin
      outValid  <= stb.lkCapture;
      outHit    <= stb.lkCapture && selHit;
      outRegion <= (stb.lkCapture && selHit) ? selIdx  : '0;
      outAddr   <= (stb.lkCapture && selHit) ? selAddr : '0;
      outType   <= (stb.lkCapture && selHit) ? selType : '0;
    end
  end
endmodule

// File: rtl/ob_addr_xlate.sv
module ob_addr_xlate
  import ob_xlate_pkg::*;
#(
  parameter int AW          = 32,
  parameter int REG_AW      = 12,
  parameter int WIN_BASE    = 'h900,
  parameter int TYPE_W      = 5,
  parameter int NUM_REGIONS = 3,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regWrData,
  output logic [AW-1:0]     regRdData,
  input  logic              lkValid,
  input  logic [AW-1:0]     lkAddr,
  output logic              outValid,
  output logic              outHit,
  output logic [IDX_W-1:0]  outRegion,
  output logic [2*AW-1:0]   outAddr,
  output logic [TYPE_W-1:0] outType
);
  strobes_t         stb;
  logic [IDX_W-1:0] regionSel;
  logic [AW-1:0]    dpRdData;

  ob_xlate_ctrl #(.AW(AW), .REG_AW(REG_AW), .WIN_BASE(WIN_BASE),
                  .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .lkValid(lkValid), .dpRdData(dpRdData),
    .stb(stb), .regionSel(regionSel), .regRdData(regRdData)
  );

  ob_xlate_dp #(.AW(AW), .TYPE_W(TYPE_W), .NUM_REGIONS(NUM_REGIONS),
                .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regionSel(regionSel),
    .regWrData(regWrData), .lkAddr(lkAddr), .dpRdData(dpRdData),
    .outValid(outValid), .outHit(outHit), .outRegion(outRegion),
    .outAddr(outAddr), .outType(outType)
  );
endmodule

// File: rtl/ob_addr_xlate_chk.sv
module ob_addr_xlate_chk #(
  parameter int AW          = 32,
  parameter int TYPE_W      = 5,
  parameter int NUM_REGIONS = 3,
  parameter int IDX_W       = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              outValid,
  input logic              outHit,
  input logic [IDX_W-1:0]  outRegion,
  input logic [2*AW-1:0]   outAddr,
  input logic [TYPE_W-1:0] outType
);
  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> outValid);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !outValid);
  // R9
  miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outHit |-> (outAddr == '0 && outType == '0 && outRegion == '0));
  // R7
  hit_region_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> (outValid && outRegion < IDX_W'(NUM_REGIONS)));
endmodule

bind ob_addr_xlate ob_addr_xlate_chk #(.AW(AW), .TYPE_W(TYPE_W),
  .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .outValid(outValid),
  .outHit(outHit), .outRegion(outRegion), .outAddr(outAddr), .outType(outType)
);

// File: tb/ob_addr_xlate_tb_top.sv
module ob_addr_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        outValid, outHit;
  logic [1:0]  outRegion;
  logic [63:0] outAddr;
  logic [4:0]  outType;

  always #4 clk = ~clk;

  ob_addr_xlate dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lkValid(lkValid),
    .lkAddr(lkAddr), .outValid(outValid), .outHit(outHit),
    .outRegion(outRegion), .outAddr(outAddr), .outType(outType)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mBlo [3], mBhi [3], mLim [3], mTlo [3], mThi [3];
  logic [4:0]  mTyp [3];
  logic        mEn  [3];

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setRegion(input int r, input logic [31:0] blo, input logic [31:0] lim,
                           input logic [31:0] tlo, input logic [31:0] thi,
                           input logic [4:0] typ, input logic en);
    wr(12'h900, r);
    wr(12'h90C, blo);  mBlo[r] = blo;
    wr(12'h914, lim);  mLim[r] = lim;
    wr(12'h918, tlo);  mTlo[r] = tlo;
    wr(12'h91C, thi);  mThi[r] = thi;
    wr(12'h904, 32'(typ)); mTyp[r] = typ;
    wr(12'h908, {en, 31'b0}); mEn[r] = en;
  endtask

  task automatic look(input logic [31:0] a, input string req);
    logic h; int rg; logic [63:0] x; logic [4:0] t;
    h = 0; rg = 0; x = '0; t = '0;
    for (int i = 2; i >= 0; i--)
      if (mEn[i] && a >= mBlo[i] && a <= mLim[i]) begin
        h = 1; rg = i; x = {mThi[i], mTlo[i]} + {32'b0, a - mBlo[i]}; t = mTyp[i];
      end
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a;
    @(negedge clk);
    lkValid = 1'b0;
    check({req, " valid"}, 64'(outValid), 64'd1);
    check({req, " R5 hit"}, 64'(outHit), 64'(h));
    check({req, " R8 region"}, 64'(outRegion), 64'(rg));
    check({req, " R6 addr"}, outAddr, x);
    check({req, " R7 type"}, 64'(outType), 64'(t));
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 3; r++) begin
      look(mBlo[r] - 1, req); look(mBlo[r], req);
      look(mLim[r], req);     look(mLim[r] + 1, req);
    end
    for (int i = 0; i < 48; i++)
      look(32'(i) * 32'h0005_5000 + 32'(i % 7) * 32'h0000_3FFF, req);
    look(32'h01FF_8000, req); look(32'hFFFF_FFFF, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [11:0] offs [8];
    offs = '{12'h900, 12'h904, 12'h908, 12'h90C, 12'h910, 12'h914, 12'h918, 12'h91C};
    for (int r = 0; r < 3; r++) begin
      mBlo[r] = 0; mBhi[r] = 0; mLim[r] = 0; mTlo[r] = 0; mThi[r] = 0; mTyp[r] = 0; mEn[r] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of all registers of every region
    for (int r = 0; r < 3; r++) begin
      wr(12'h900, r);
      for (int f = 1; f < 8; f++) begin rd(offs[f], d); check("R1 reset reg", 64'(d), 64'd0); end
    end
    wr(12'h900, 0);
    rd(12'h900, d); check("R1 viewport", 64'(d), 64'd0);
    look(32'h0000_0000, "R1 miss");
    look(32'h01FF_0000, "R1 miss");

    // R2 R3: read-back per field per region, region isolation
    for (int r = 0; r < 3; r++) begin
      wr(12'h900, r);
      wr(12'h904, 32'hFFFF_FFE0 | 32'(r + 1));
      wr(12'h908, 32'h7FFF_FFFF);
      for (int f = 3; f < 8; f++) wr(offs[f], 32'hA5000000 | (r << 8) | f);
    end
    for (int r = 0; r < 3; r++) begin
      wr(12'h900, r);
      rd(12'h900, d); check("R2 viewport", 64'(d), 64'(r));
      rd(12'h904, d); check("R2 type field", 64'(d), 64'(r + 1));
      rd(12'h908, d); check("R2 enable field", 64'(d), 64'd0);
      for (int f = 3; f < 8; f++) begin
        rd(offs[f], d); check("R3 region field", 64'(d), 64'(32'hA5000000 | (r << 8) | f));
      end
    end
    wr(12'h900, 1); wr(12'h908, 32'hFFFF_FFFF);
    rd(12'h908, d); check("R2 enable bit31", 64'(d), 64'h8000_0000);
    wr(12'h908, 0);

    // R4: viewport out of range
    wr(12'h900, 3);
    rd(12'h900, d); check("R4 viewport readback", 64'(d), 64'd3);
    wr(12'h90C, 32'hDEAD_BEEF); wr(12'h904, 5);
    rd(12'h90C, d); check("R4 read zero", 64'(d), 64'd0);
    rd(12'h904, d); check("R4 read zero", 64'(d), 64'd0);
    wr(12'h900, 32'h8000_0000); wr(12'h914, 32'h1234_5678);
    for (int r = 0; r < 3; r++) begin
      wr(12'h900, r);
      rd(12'h90C, d); check("R4 untouched", 64'(d), 64'(32'hA5000003 | (r << 8)));
      rd(12'h914, d); check("R4 untouched", 64'(d), 64'(32'hA5000005 | (r << 8)));
      rd(12'h904, d); check("R4 untouched", 64'(d), 64'(r + 1));
    end

    // R10: outside the window and unaligned
    wr(12'h900, 0);
    wr(12'h920, 32'h1111_1111); wr(12'h8FC, 32'h2222_2222); wr(12'h90D, 32'h3333_3333);
    rd(12'h920, d); check("R10 outside read", 64'(d), 64'd0);
    rd(12'h8FC, d); check("R10 outside read", 64'(d), 64'd0);
    rd(12'h90D, d); check("R10 unaligned read", 64'(d), 64'd0);
    rd(12'h90C, d); check("R10 untouched", 64'(d), 64'h0000_0000_A500_0003);

    // R5 R6 R7 R8: overlapping regions, carry into high half
    setRegion(0, 32'h01FF_0000, 32'h01FF_FFFF, 32'h0000_0000, 32'h0000_0000, 5'd4, 1'b1);
    setRegion(1, 32'h0000_0000, 32'h0000_FFFF, 32'h0010_0000, 32'h0000_0000, 5'd2, 1'b1);
    setRegion(2, 32'h0000_8000, 32'h00FE_FFFF, 32'hFFFF_0000, 32'h0000_0001, 5'd0, 1'b1);
    sweep("R5 R8 all enabled");
    look(32'h0002_0000, "R6 carry");
    check("R6 carry explicit", outAddr, 64'h0000_0002_0000_8000);
    // R9: no valid without a request
    @(negedge clk);
    check("R9 idle valid", 64'(outValid), 64'd0);

    // R5 R8: disable region 1, region 2 takes the overlap
    wr(12'h900, 1); wr(12'h908, 0); mEn[1] = 0;
    sweep("R8 r1 disabled");
    // R5: limit below base never matches; type-1 config code
    setRegion(0, 32'h0300_0000, 32'h02FF_FFFF, 32'h0, 32'h0, 5'd5, 1'b1);
    setRegion(1, 32'h0200_0000, 32'h02FF_FFFF, 32'h4000_0000, 32'hFFFF_FFFF, 5'd1, 1'b1);
    sweep("R5 inverted region");
    look(32'h0300_0000, "R5 inverted");
    look(32'h02FF_FFFF, "R7 locked type");

    finishRun();
  end
endmodule